// File: doc/BRIEF.md
# Stepping Wiper Position Register

This block keeps the tap position of one digitally controlled potentiometer as a 6-bit volatile register. It also turns that position into a registered one-hot select for the 64 tap switches of the resistor string. The position changes in four ways:

- **Host write:** a serial-path write loads a new value from the host.
- **Stored-register load:** a parallel load copies a value from a stored register.
- **Stepping:** a fine-tuning phase moves the wiper one tap at a time under bus clock pulses.
- **Reset recall:** reset loads the recall value of stored register 0.

The stepping phase is armed by a pulse from the bus front end after the increment/decrement command has been acknowledged. It stays open until the front end reports a stop condition. While the phase is open, each rising edge of the bus clock is one step, and the data line level at that edge gives the direction. The bus lines are brought into the block clock domain through synchronizer stages before edge detection.

Top module: `wiper_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `pos` takes `recall_val` and `tap_sel` takes the one-hot code of `recall_val`. The value held before reset is not kept.
- R2: A cycle with `wr_load` high sets `pos` to `wr_data` at that clock edge.
- R3: A cycle with `xfr_load` high and `wr_load` low sets `pos` to `xfr_data`. When both strobes are high, `wr_data` wins.
- R4: While stepping is open, each rising edge of `bus_scl` with `bus_sda` high raises `pos` by one.
- R5: While stepping is open, each rising edge of `bus_scl` with `bus_sda` low lowers `pos` by one.
- R6: Stepping saturates. An up step at 6'h3F leaves `pos` at 6'h3F, and a down step at 6'h00 leaves `pos` at 6'h00.
- R7: A pulse on `step_arm` opens stepping, and a pulse on `step_stop` closes it. If both come in the same cycle, stepping stays closed. Reset closes stepping. Clock pulses outside stepping leave `pos` unchanged.
- R8: `tap_sel` always has exactly one bit set, at index `pos`. Bit 0 is the low-end tap and bit 63 is the high-end tap. `tap_sel` follows `pos` one clock later.
- R9: One high pulse of `bus_scl` moves the wiper at most one tap, however long the pulse lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| recall_val | input | 6 | Stored register 0 value, loaded at reset |
| wr_load | input | 1 | Host write strobe |
| wr_data | input | 6 | Host write value |
| xfr_load | input | 1 | Stored-register transfer strobe |
| xfr_data | input | 6 | Stored-register value |
| step_arm | input | 1 | Opens stepping after the command acknowledge |
| step_stop | input | 1 | Closes stepping on a stop condition |
| bus_scl | input | 1 | Bus clock line (asynchronous) |
| bus_sda | input | 1 | Bus data line (asynchronous) |
| pos | output | 6 | Wiper position |
| tap_sel | output | 64 | Registered one-hot tap select |

## Verification
A load strobe that is high at edge k shows on `pos` at edge k and on `tap_sel` at edge k+1. The bench drops each strobe after one edge and checks both outputs at the following falling edge.

A `bus_scl` rise first passes two synchronizer flops, so `pos` moves on the third clock edge after the rise and `tap_sel` on the fourth. The bench sets `bus_sda` two cycles before raising `bus_scl`. It then waits four falling edges after lowering `bus_scl` before it compares, so every check sees a settled result.

Expected positions come from a bench-side model that adds or subtracts one per pulse and clamps at the ends.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/wiper_step_sampler.sv
module wiper_step_sampler
  import wiper_pkg::*;
#(
  parameter int SYNC_LEN = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bus_scl,
  input  logic  bus_sda,
  input  logic  step_arm,
  input  logic  step_stop,
  output logic  step_mode,
  output step_e step_cmd
);
  logic [SYNC_LEN-1:0] scl_sh, sda_sh;
  logic                scl_prev;
  logic                scl_q, sda_q;

  assign scl_q = scl_sh[SYNC_LEN-1];
  assign sda_q = sda_sh[SYNC_LEN-1];

  // Bus lines idle high, so the synchronizers reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[SYNC_LEN-2:0], bus_scl};
      sda_sh   <= {sda_sh[SYNC_LEN-2:0], bus_sda};
      scl_prev <= scl_q;
    end
  end

  // A stop condition overrides an arm pulse in the same cycle.
  always_ff @(posedge clk) begin
    if (rst || step_stop) step_mode <= 1'b0;
    else if (step_arm)    step_mode <= 1'b1;
  end

  always_comb begin
    step_cmd = STEP_NONE;
    if (step_mode && scl_q && !scl_prev)
      step_cmd = sda_q ? STEP_UP : STEP_DN;
  end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wiper_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] recall_val,
  input  logic             wr_load,
  input  logic [POS_W-1:0] wr_data,
  input  logic             xfr_load,
  input  logic [POS_W-1:0] xfr_data,
  input  step_e            step_cmd,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  always_ff @(posedge clk) begin
    if (rst)                                  pos <= recall_val;
    else if (wr_load)                         pos <= wr_data;
    else if (xfr_load)                        pos <= xfr_data;
    else if (step_cmd == STEP_UP && pos != POS_MAX) pos <= pos + 1'b1;
    else if (step_cmd == STEP_DN && pos != POS_MIN) pos <= pos - 1'b1;
  end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int POS_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [POS_W-1:0]      recall_val,
  input  logic [POS_W-1:0]      pos,
  output logic [(1<<POS_W)-1:0] tap_sel
);
  localparam int TAPS = 1 << POS_W;

  logic [POS_W-1:0] sel;
  assign sel = rst ? recall_val : pos;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk) tap_sel[i] <= (sel == POS_W'(i));
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int POS_W    = 6,
  parameter int SYNC_LEN = 2,
  localparam int TAPS    = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] recall_val,
  input  logic             wr_load,
  input  logic [POS_W-1:0] wr_data,
  input  logic             xfr_load,
  input  logic [POS_W-1:0] xfr_data,
  input  logic             step_arm,
  input  logic             step_stop,
  input  logic             bus_scl,
  input  logic             bus_sda,
  output logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap_sel
);
  logic  step_mode;
  step_e step_cmd;

  wiper_step_sampler #(.SYNC_LEN(SYNC_LEN)) u_sampler (
    .clk(clk), .rst(rst), .bus_scl(bus_scl), .bus_sda(bus_sda),
    .step_arm(step_arm), .step_stop(step_stop),
    .step_mode(step_mode), .step_cmd(step_cmd)
  );

  wiper_pos_reg #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .recall_val(recall_val),
    .wr_load(wr_load), .wr_data(wr_data),
    .xfr_load(xfr_load), .xfr_data(xfr_data),
    .step_cmd(step_cmd), .pos(pos)
  );

  wiper_tap_decode #(.POS_W(POS_W)) u_dec (
    .clk(clk), .rst(rst), .recall_val(recall_val),
    .pos(pos), .tap_sel(tap_sel)
  );
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst,
  input logic [POS_W-1:0] recall_val,
  input logic             wr_load,
  input logic [POS_W-1:0] wr_data,
  input logic             xfr_load,
  input logic [POS_W-1:0] xfr_data,
  input logic             step_mode,
  input logic [POS_W-1:0] pos,
  input logic [TAPS-1:0]  tap_sel
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  assert_reset_recall_R1: assert property (@(posedge clk)
    rst |=> pos == $past(recall_val));

  assert_wr_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_load |=> pos == $past(wr_data));

  assert_xfr_load_R3: assert property (@(posedge clk) disable iff (rst)
    (xfr_load && !wr_load) |=> pos == $past(xfr_data));

  assert_step_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_load && !xfr_load) |=>
      (pos == $past(pos)) ||
      ($past(pos) != POS_MAX && pos == $past(pos) + 1'b1) ||
      ($past(pos) != '0 && pos == $past(pos) - 1'b1));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_mode && !wr_load && !xfr_load) |=> $stable(pos));

  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel) == 1);

  assert_tap_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tap_sel[$past(pos)]);
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst(rst), .recall_val(recall_val),
  .wr_load(wr_load), .wr_data(wr_data),
  .xfr_load(xfr_load), .xfr_data(xfr_data),
  .step_mode(step_mode), .pos(pos), .tap_sel(tap_sel)
);

// File: tb/wiper_ctrl_test.sv
`timescale 1ns/1ps
module wiper_ctrl_test;
  localparam int POS_W = 6;
  localparam int TAPS  = 1 << POS_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [POS_W-1:0] recall_val = 6'h15;
  logic             wr_load = 1'b0, xfr_load = 1'b0;
  logic [POS_W-1:0] wr_data = '0, xfr_data = '0;
  logic             step_arm = 1'b0, step_stop = 1'b0;
  logic             bus_scl = 1'b1, bus_sda = 1'b1;
  logic [POS_W-1:0] pos;
  logic [TAPS-1:0]  tap_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int model;

  always #5 clk = ~clk;

  wiper_ctrl #(.POS_W(POS_W)) uut (
    .clk(clk), .rst(rst), .recall_val(recall_val),
    .wr_load(wr_load), .wr_data(wr_data),
    .xfr_load(xfr_load), .xfr_data(xfr_data),
    .step_arm(step_arm), .step_stop(step_stop),
    .bus_scl(bus_scl), .bus_sda(bus_sda),
    .pos(pos), .tap_sel(tap_sel)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(int exp, string req);
    logic [TAPS-1:0] exp_tap;
    exp_tap = TAPS'(1) << exp;
    checks++;
    if (pos !== POS_W'(exp) || tap_sel !== exp_tap) begin
      errors++;
      $display("FAIL %s: pos=%0d tap=%h expected pos=%0d tap=%h",
               req, pos, tap_sel, exp, exp_tap);
    end
  endtask

  task automatic do_reset(logic [POS_W-1:0] r);
    @(negedge clk); recall_val = r; rst = 1'b1;
    tick(2); rst = 1'b0;
  endtask

  task automatic host_wr(logic [POS_W-1:0] d);
    @(negedge clk); wr_load = 1'b1; wr_data = d;
    @(negedge clk); wr_load = 1'b0;
    tick(1);
  endtask

  task automatic pulse(logic d, int hi);
    @(negedge clk); bus_sda = d;
    tick(2); bus_scl = 1'b1;
    tick(hi); bus_scl = 1'b0;
    tick(4);
  endtask

  task automatic arm();
    @(negedge clk); step_arm = 1'b1;
    @(negedge clk); step_arm = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk); step_stop = 1'b1;
    @(negedge clk); step_stop = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset recall
    tick(3); rst = 1'b0; tick(1);
    check(6'h15, "R1 reset recall");
    host_wr(6'h2A); check(6'h2A, "R2 before reset");
    do_reset(6'h07); tick(1); check(6'h07, "R1 recall not old value");

    // R2, R8: exhaustive host writes
    for (int v = 0; v < TAPS; v++) begin
      host_wr(POS_W'(TAPS - 1 - v));
      check(TAPS - 1 - v, "R2/R8 write sweep");
    end

    // R3: transfer load and priority
    @(negedge clk); xfr_load = 1'b1; xfr_data = 6'h33;
    @(negedge clk); xfr_load = 1'b0; tick(1);
    check(6'h33, "R3 transfer load");
    @(negedge clk); xfr_load = 1'b1; xfr_data = 6'h01; wr_load = 1'b1; wr_data = 6'h3E;
    @(negedge clk); xfr_load = 1'b0; wr_load = 1'b0; tick(1);
    check(6'h3E, "R3 write wins over transfer");

    // R7: pulses ignored before arming
    host_wr(6'h10);
    pulse(1'b1, 2); pulse(1'b0, 2);
    check(6'h10, "R7 idle pulses ignored");

    // R4, R6: step up across full range, then saturate
    host_wr(6'h00); model = 0;
    arm();
    for (int i = 0; i < TAPS + 1; i++) begin
      pulse(1'b1, 2);
      model = (model < TAPS - 1) ? model + 1 : model;
      check(model, i < TAPS - 1 ? "R4 step up" : "R6 saturate high");
    end
    // R5, R6: step down to bottom, then saturate
    for (int i = 0; i < TAPS + 1; i++) begin
      pulse(1'b0, 2);
      model = (model > 0) ? model - 1 : model;
      check(model, i < TAPS - 1 ? "R5 step down" : "R6 saturate low");
    end

    // R9: long pulses give single steps
    pulse(1'b1, 20); check(1, "R9 long pulse one step");
    pulse(1'b1, 1);  check(2, "R9 short pulse one step");

    // R7: stop closes stepping
    stop();
    pulse(1'b1, 2); check(2, "R7 ignored after stop");

    // R7: arm and stop together keep stepping closed
    @(negedge clk); step_arm = 1'b1; step_stop = 1'b1;
    @(negedge clk); step_arm = 1'b0; step_stop = 1'b0;
    pulse(1'b0, 2); check(2, "R7 stop wins over arm");

    // R7: reset closes stepping
    arm(); pulse(1'b1, 2); check(3, "R4 step after rearm");
    do_reset(6'h20); tick(1);
    pulse(1'b1, 2); check(6'h20, "R7 reset closes stepping");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule